// File: doc/BRIEF.md
# Segment insertion bit cell

This block is a one-bit reconfigurable cell for an on-chip instrument scan network. It holds a latched control bit that decides whether a downstream segment is part of the scan path. While the cell is closed, serial data runs from the cell's scan input into its own one-bit shift stage, and the segment on its hierarchical port is left out of the path. While the cell is open, the path leaves through the segment-input pin, runs through the attached segment, and comes back on the segment-output pin into the shift stage. The attached segment therefore sits upstream of the cell's own bit.

The network distributes the shift, capture and update strobes to every cell. Each cell acts on them only while its own select input is high. A cell forwards select to its child segment only while it is open, so closing a parent cell deselects its whole subtree. A new control bit is shifted into the shift stage and becomes the open/closed state on the update strobe. A capture loads the present state into the shift stage, so the next shift reports it on the scan output.

Scan data here moves one bit per strobe and has no valid/ready handshake. Every pin is a plain control or data level that is sampled on the rising clock edge.

Top module: `sib_cell`

## Requirements
- R1: When rst_n is low, the cell is closed (state 0) and the shift stage is cleared. After reset, scan_out_o is 0 and seg_sel_o is 0.
- R2: While closed, a gated shift loads scan_in_i into the shift stage, and seg_so_i has no effect.
- R3: While open (state 1), a gated shift loads seg_so_i into the shift stage, and scan_in_i has no effect on it.
- R4: seg_si_o equals scan_in_i while the cell is open and is 0 while it is closed.
- R5: seg_sel_o is high exactly when sel_i is high and the cell is open.
- R6: With sel_i low, the shift, capture and update strobes have no effect on the shift stage or on the state.
- R7: The state changes only on a gated update, which copies the shift-stage value held just before that clock edge. When shift and update are asserted in the same cycle, the state receives the old shift-stage bit.
- R8: A gated capture loads the current state into the shift stage. Capture takes priority over shift when both are asserted.
- R9: scan_out_o always shows the shift-stage register, so a shifted bit appears on scan_out_o one clock after the shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_i | input | 1 | Cell select from the parent or the gateway |
| shift_en_i | input | 1 | Shared shift strobe |
| capture_en_i | input | 1 | Shared capture strobe |
| update_en_i | input | 1 | Shared update strobe |
| scan_in_i | input | 1 | Serial scan input |
| scan_out_o | output | 1 | Serial scan output (shift stage) |
| seg_si_o | output | 1 | Serial data toward the attached segment |
| seg_so_i | input | 1 | Serial data returning from the attached segment |
| seg_sel_o | output | 1 | Select driven to the attached segment |

## Verification
The assertions take the strobes to be synchronous levels that are sampled on the rising edge. They allow any combination of strobes, including shift together with capture or update, and treat select low as full isolation of the cell. The stimulus changes every input on the falling edge and holds it across the next rising edge. It deliberately combines strobes, and asserts strobes with select low, to reach the priority and isolation corners. The expected values come from a model of the state and the shift bit written in the requirements.

// File: rtl/sib_pkg.sv
package sib_pkg;
  typedef enum logic {
    SIB_CLOSED = 1'b0,
    SIB_OPEN   = 1'b1
  } sib_state_e;

  typedef struct packed {
    logic shift;
    logic capture;
    logic update;
  } sib_strobes_t;
endpackage

// File: rtl/sib_strobe_gate.sv
module sib_strobe_gate
  import sib_pkg::*;
(
  input  logic         sel_i,
  input  logic         shift_en_i,
  input  logic         capture_en_i,
  input  logic         update_en_i,
  output sib_strobes_t strb_o
);
  always_comb begin
    strb_o.shift   = sel_i & shift_en_i;
    strb_o.capture = sel_i & capture_en_i;
    strb_o.update  = sel_i & update_en_i;
  end
endmodule

// File: rtl/sib_shift_stage.sv
module sib_shift_stage
  import sib_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       shift_i,
  input  logic       capture_i,
  input  sib_state_e state_i,
  input  logic       scan_in_i,
  input  logic       seg_so_i,
  output logic       q_o
);
  logic path_bit;

  always_comb begin
    path_bit = (state_i == SIB_OPEN) ? seg_so_i : scan_in_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         q_o <= 1'b0;
    else if (capture_i) q_o <= state_i;
    else if (shift_i)   q_o <= path_bit;
  end

  // R8
  capture_loads_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture_i |=> (q_o == $past(state_i)));

  // R6
  hold_without_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!capture_i && !shift_i) |=> $stable(q_o));

  // R3
  open_shift_child_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_i && !capture_i && state_i == SIB_OPEN) |=> (q_o == $past(seg_so_i)));

  // R2
  closed_shift_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_i && !capture_i && state_i == SIB_CLOSED) |=> (q_o == $past(scan_in_i)));
endmodule

// File: rtl/sib_state_reg.sv
module sib_state_reg
  import sib_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       update_i,
  input  logic       d_i,
  output sib_state_e state_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_o <= SIB_CLOSED;
    else if (update_i) state_o <= sib_state_e'(d_i);
  end

  // R7
  state_only_on_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !update_i |=> $stable(state_o));

  // R7
  update_takes_old_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    update_i |=> (state_o == sib_state_e'($past(d_i))));
endmodule

// File: rtl/sib_cell.sv
module sib_cell
  import sib_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sel_i,
  input  logic shift_en_i,
  input  logic capture_en_i,
  input  logic update_en_i,
  input  logic scan_in_i,
  output logic scan_out_o,
  output logic seg_si_o,
  input  logic seg_so_i,
  output logic seg_sel_o
);
  sib_strobes_t strb;
  sib_state_e   state;
  logic         shift_q;

  sib_strobe_gate u_gate (
    .sel_i        (sel_i),
    .shift_en_i   (shift_en_i),
    .capture_en_i (capture_en_i),
    .update_en_i  (update_en_i),
    .strb_o       (strb)
  );

  sib_shift_stage u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_i   (strb.shift),
    .capture_i (strb.capture),
    .state_i   (state),
    .scan_in_i (scan_in_i),
    .seg_so_i  (seg_so_i),
    .q_o       (shift_q)
  );

  sib_state_reg u_state (
    .clk      (clk),
    .rst_n    (rst_n),
    .update_i (strb.update),
    .d_i      (shift_q),
    .state_o  (state)
  );

  always_comb begin
    scan_out_o = shift_q;
    seg_si_o   = (state == SIB_OPEN) ? scan_in_i : 1'b0;
    seg_sel_o  = sel_i & (state == SIB_OPEN);
  end

  // R6
  deselected_isolation_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_i |=> ($stable(scan_out_o) && $stable(state)));

  // R1
  reset_closed_chk: assert property (@(posedge clk)
    !rst_n |-> (scan_out_o == 1'b0 && seg_sel_o == 1'b0 && seg_si_o == 1'b0));

  // R5
  child_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seg_sel_o |-> (sel_i && state == SIB_OPEN));
endmodule

// File: tb/tb_sib_cell.sv
module tb_sib_cell;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_i = 1'b0, shift_en_i = 1'b0, capture_en_i = 1'b0, update_en_i = 1'b0;
  logic scan_in_i = 1'b0, seg_so_i = 1'b0;
  logic scan_out_o, seg_si_o, seg_sel_o;
  int   n_vec = 0;
  int   n_bad = 0;

  always #5 clk = ~clk;

  sib_cell dut (
    .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .shift_en_i(shift_en_i),
    .capture_en_i(capture_en_i), .update_en_i(update_en_i),
    .scan_in_i(scan_in_i), .scan_out_o(scan_out_o), .seg_si_o(seg_si_o),
    .seg_so_i(seg_so_i), .seg_sel_o(seg_sel_o)
  );

  // {sel, shift, capture, update, scan_in, seg_so, exp_out, exp_segsel, exp_segsi}
  localparam int NV = 13;
  localparam logic [8:0] VEC [NV] = '{
    9'b1_1_0_0_1_0_1_0_0, // R2 closed shift of 1 from scan_in
    9'b1_0_0_1_1_0_1_1_1, // R7 update opens; R4 and R5 follow
    9'b1_1_0_0_0_1_1_1_0, // R3 open shift takes the child bit 1
    9'b1_1_0_0_1_0_0_1_1, // R3 open shift takes the child bit 0, scan_in ignored
    9'b0_1_1_1_1_1_0_0_1, // R6 deselected: strobes ignored, still open
    9'b1_0_1_0_0_0_1_1_0, // R8 capture loads state 1
    9'b1_1_1_0_0_0_1_1_0, // R8 capture wins over shift
    9'b1_1_0_0_0_0_0_1_0, // R3 shift a 0 in from the child
    9'b1_0_0_1_1_1_0_0_0, // R7 update closes
    9'b1_1_0_0_0_1_0_0_0, // R2 closed, seg_so ignored
    9'b1_0_1_0_0_0_0_0_0, // R8 capture loads state 0
    9'b1_1_0_1_1_0_1_0_0, // R7 shift and update together: state takes the old 0
    9'b1_0_0_1_0_0_1_1_0  // R7 update now opens with 1
  };

  task automatic chk(input string req, input logic act, input logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    fork
      begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
      begin
        scan_in_i = 1'b1; sel_i = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R1 scan_out", scan_out_o, 1'b0);
        chk("R1 seg_sel", seg_sel_o, 1'b0);
        chk("R1 seg_si", seg_si_o, 1'b0);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
          {sel_i, shift_en_i, capture_en_i, update_en_i, scan_in_i, seg_so_i} = VEC[i][8:3];
          @(posedge clk);
          @(negedge clk);
          chk("R9 scan_out", scan_out_o, VEC[i][2]);
          chk("R5 seg_sel", seg_sel_o, VEC[i][1]);
          chk("R4 seg_si", seg_si_o, VEC[i][0]);
        end
        // The cell is open with the shift bit at 1; a mid-run reset must close it
        sel_i = 1'b1; scan_in_i = 1'b1; shift_en_i = 1'b0; capture_en_i = 1'b0; update_en_i = 1'b0;
        chk("R5 pre-reset seg_sel", seg_sel_o, 1'b1);
        rst_n = 1'b0;
        #1;
        chk("R1 mid-run scan_out", scan_out_o, 1'b0);
        chk("R1 mid-run seg_sel", seg_sel_o, 1'b0);
        chk("R4 mid-run seg_si", seg_si_o, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule